// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupt Detection

This block is a memory-mapped general-purpose I/O controller that serves three banks of 32 pins behind a simple 32-bit register bus. Software programs a direction and an input inversion for each pin. It drives outputs through a plain data register or through write-only set and clear ports, so one bit can change without a read-modify-write. It reads back the current pin state.

Each input goes through a two-flop synchronizer and then through the optional inversion. A detector then looks for four conditions: a rising edge, a falling edge, a high level and a low level. Each condition has its own per-pin enable. Detected events latch into a per-bank pending register that software clears by writing 1. A second per-bank register keeps only the events that came from edges. The pending bits of all banks are ORed onto one interrupt line.

The bus is a single-cycle write strobe with a combinational read path. Word addresses are built as function base plus 4 × bank.

Top module: `gpio_ctrl`

## Requirements
- R1: A register is selected by address bits [7:4] (function) and [3:2] (bank 0..2). The function codes are 0 direction, 1 inversion, 2 data, 3 set port, 4 clear port, 5 rising enable, 6 falling enable, 7 high-level enable, 8 low-level enable, 9 pending, 10 edge-pending. Reads of any other function, of bank index 3, or of an address with bits [1:0] not zero return 0, and writes to them change nothing.
- R2: When a direction bit is 1, pin_oe_o for that pin is 1 and pin_o carries the output latch bit. When the direction bit is 0, pin_oe_o is 0.
- R3: A write to the set port sets each output latch bit written as 1. A write to the clear port clears each bit written as 1. Bits written as 0 keep their value. Both ports read as 0, and a write to the data register loads the latch directly.
- R4: A data read returns, for output pins, the latch bit. For input pins it returns the synchronized input XOR the inversion bit. An input change applied before clock edge k shows in the readback after edge k+1.
- R5: After reset the inversion register is 0. A 1 in it inverts the pin for readback and for all event detection.
- R6: With the rising (or falling) enable set, a 0→1 (or 1→0) change of the inverted input sets the pending bit at the third clock edge after the change. With both enables set, both edges are detected.
- R7: With the high-level (or low-level) enable set, the pending bit is set again on every clock while the inverted input is 1 (or 0). A clear therefore only holds once the level has gone away.
- R8: Writing 1 to a pending bit clears it and writing 0 leaves it alone. A new event in the same cycle wins over the clear.
- R9: A pin whose four enables are all 0 never sets its pending bit.
- R10: irq_o is 1 exactly when any pending bit of any bank is 1.
- R11: The edge-pending register sets a bit only on an enabled edge event. It is cleared by writing 1 to it and follows the same rules as R8.
- R12: After reset every register, every output latch bit, pin_oe_o and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Write strobe for one cycle |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pin_i | input | 96 | Pin inputs, bank b at bits [32b+31:32b] |
| pin_o | output | 96 | Output latch values |
| pin_oe_o | output | 96 | Output enables (direction) |
| irq_o | output | 1 | Shared interrupt |

## Verification
The assertions rely on two facts about the bus. At most one function strobe is active per cycle. Write data is only meaningful while wr_i is high, so the set/clear and clear-on-write properties compare against the data sampled with the strobe. Pin inputs may be asynchronous. The properties read only the synchronized level, so the stimulus changes pins away from the clock edge and holds each value for whole cycles. The stimulus writes at random into the unmapped functions and into bank slot 3, as well as into the live registers, so that decode leaks appear as mismatches on the outputs that are compared every cycle.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int ADDR_W = 8;
  localparam int FN_W   = 4;
  localparam int BANK_W = 2;

  typedef enum logic [FN_W-1:0] {
    FN_DIR  = 4'd0,
    FN_POL  = 4'd1,
    FN_DAT  = 4'd2,
    FN_SET  = 4'd3,
    FN_CLR  = 4'd4,
    FN_REN  = 4'd5,
    FN_FEN  = 4'd6,
    FN_HEN  = 4'd7,
    FN_LEN  = 4'd8,
    FN_STS  = 4'd9,
    FN_EDG  = 4'd10
  } gpio_fn_e;

  typedef struct packed {
    logic dir;
    logic pol;
    logic dat;
    logic dset;
    logic dclr;
    logic ren;
    logic fen;
    logic hen;
    logic len;
    logic sts;
    logic edg;
  } bank_wr_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] ren_i,
  input  logic [W-1:0] fen_i,
  input  logic [W-1:0] hen_i,
  input  logic [W-1:0] len_i,
  output logic [W-1:0] sts_set_o,
  output logic [W-1:0] edg_set_o
);
  logic [W-1:0] prev_q, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  assign rise      = lvl_i & ~prev_q;
  assign fall      = ~lvl_i & prev_q;
  assign edg_set_o = (rise & ren_i) | (fall & fen_i);
  assign sts_set_o = edg_set_o | (lvl_i & hen_i) | (~lvl_i & len_i);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_ctrl_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  bank_wr_t     wr_i,
  input  logic [W-1:0] wdata_i,
  input  gpio_fn_e     fn_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oe_o,
  output logic [W-1:0] rdata_o,
  output logic         irq_o
);
  logic [W-1:0] dir_q, pol_q, out_q;
  logic [W-1:0] ren_q, fen_q, hen_q, len_q;
  logic [W-1:0] sts_q, edg_q;
  logic [W-1:0] sync, lvl, sts_set, edg_set;

  gpio_sync #(.W(W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync)
  );

  assign lvl = sync ^ pol_q;

  gpio_detect #(.W(W)) u_det (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lvl_i    (lvl),
    .ren_i    (ren_q),
    .fen_i    (fen_q),
    .hen_i    (hen_q),
    .len_i    (len_q),
    .sts_set_o(sts_set),
    .edg_set_o(edg_set)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      pol_q <= '0;
      out_q <= '0;
      ren_q <= '0;
      fen_q <= '0;
      hen_q <= '0;
      len_q <= '0;
      sts_q <= '0;
      edg_q <= '0;
    end else begin
      if (wr_i.dir) dir_q <= wdata_i;
      if (wr_i.pol) pol_q <= wdata_i;
      if (wr_i.ren) ren_q <= wdata_i;
      if (wr_i.fen) fen_q <= wdata_i;
      if (wr_i.hen) hen_q <= wdata_i;
      if (wr_i.len) len_q <= wdata_i;
      if (wr_i.dat)       out_q <= wdata_i;
      else if (wr_i.dset) out_q <= out_q | wdata_i;
      else if (wr_i.dclr) out_q <= out_q & ~wdata_i;
      // new events win over a same-cycle clear
      sts_q <= (sts_q & ~(wr_i.sts ? wdata_i : '0)) | sts_set;
      edg_q <= (edg_q & ~(wr_i.edg ? wdata_i : '0)) | edg_set;
    end
  end

  always_comb begin
    unique case (fn_i)
      FN_DIR:  rdata_o = dir_q;
      FN_POL:  rdata_o = pol_q;
      FN_DAT:  rdata_o = (dir_q & out_q) | (~dir_q & lvl);
      FN_REN:  rdata_o = ren_q;
      FN_FEN:  rdata_o = fen_q;
      FN_HEN:  rdata_o = hen_q;
      FN_LEN:  rdata_o = len_q;
      FN_STS:  rdata_o = sts_q;
      FN_EDG:  rdata_o = edg_q;
      default: rdata_o = '0;
    endcase
  end

  assign pin_o    = out_q;
  assign pin_oe_o = dir_q;
  assign irq_o    = |sts_q;

  // R3: set / clear ports
  a_r3_set_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i.dset |=> ((out_q & $past(wdata_i)) == $past(wdata_i)));
  a_r3_clr_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i.dclr |=> ((out_q & $past(wdata_i)) == '0));
  // R8: write-1 clears unless an event arrives
  a_r8_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i.sts |=> ((sts_q & $past(wdata_i & ~sts_set)) == '0));
  // R9: masked pins never become pending
  a_r9_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(ren_q | fen_q | hen_q | len_q)) == '0));
  // R7: a held enabled high level keeps the bit pending
  a_r7_level_persist: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~sts_q & $past(hen_q & lvl)) == '0));
  // R11: every new edge flag comes with a pending bit
  a_r11_edge_implies_sts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((edg_q & ~$past(edg_q) & ~sts_q) == '0));
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int PINS      = 32,
  localparam int NPIN     = NUM_BANKS * PINS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PINS-1:0]   wdata_i,
  output logic [PINS-1:0]   rdata_o,
  input  logic [NPIN-1:0]   pin_i,
  output logic [NPIN-1:0]   pin_o,
  output logic [NPIN-1:0]   pin_oe_o,
  output logic              irq_o
);
  logic [BANK_W-1:0]   bank_idx;
  gpio_fn_e            fn;
  logic                aligned;
  logic [PINS-1:0]     bank_rd  [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_irq;

  assign bank_idx = addr_i[3:2];
  assign fn       = gpio_fn_e'(addr_i[7:4]);
  assign aligned  = (addr_i[1:0] == 2'b00);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_wr_t wr_s;
    logic     sel;

    assign sel = wr_i && aligned && (bank_idx == BANK_W'(b));

    always_comb begin
      wr_s = '0;
      if (sel) begin
        unique case (fn)
          FN_DIR:  wr_s.dir  = 1'b1;
          FN_POL:  wr_s.pol  = 1'b1;
          FN_DAT:  wr_s.dat  = 1'b1;
          FN_SET:  wr_s.dset = 1'b1;
          FN_CLR:  wr_s.dclr = 1'b1;
          FN_REN:  wr_s.ren  = 1'b1;
          FN_FEN:  wr_s.fen  = 1'b1;
          FN_HEN:  wr_s.hen  = 1'b1;
          FN_LEN:  wr_s.len  = 1'b1;
          FN_STS:  wr_s.sts  = 1'b1;
          FN_EDG:  wr_s.edg  = 1'b1;
          default: wr_s = '0;
        endcase
      end
    end

    gpio_bank #(.W(PINS)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_s),
      .wdata_i (wdata_i),
      .fn_i    (fn),
      .pin_i   (pin_i[b*PINS +: PINS]),
      .pin_o   (pin_o[b*PINS +: PINS]),
      .pin_oe_o(pin_oe_o[b*PINS +: PINS]),
      .rdata_o (bank_rd[b]),
      .irq_o   (bank_irq[b])
    );

    // R1: at most one function strobe per bank per cycle
    a_r1_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(wr_s));
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (aligned && bank_idx == BANK_W'(b)) rdata_o = bank_rd[b];
    end
  end

  assign irq_o = |bank_irq;
endmodule

// File: tb/tb_gpio_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_ctrl;
  localparam int NB = 3;
  localparam int W  = 32;
  localparam int WATCHDOG = 100000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr = 1'b0;
  logic [7:0]      addr = '0;
  logic [W-1:0]    wdata = '0;
  logic [W-1:0]    rdata;
  logic [NB*W-1:0] pin_i = '0;
  logic [NB*W-1:0] pin_o, pin_oe;
  logic            irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  gpio_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  // behavioural reference state
  logic [W-1:0] m_dir[NB], m_pol[NB], m_out[NB], m_ren[NB], m_fen[NB];
  logic [W-1:0] m_hen[NB], m_len[NB], m_sts[NB], m_edg[NB];
  logic [W-1:0] m_s1[NB], m_s2[NB], m_prev[NB];

  initial for (int b = 0; b < NB; b++) begin
    m_dir[b] = 0; m_pol[b] = 0; m_out[b] = 0; m_ren[b] = 0; m_fen[b] = 0;
    m_hen[b] = 0; m_len[b] = 0; m_sts[b] = 0; m_edg[b] = 0;
    m_s1[b] = 0; m_s2[b] = 0; m_prev[b] = 0;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        m_dir[b] = 0; m_pol[b] = 0; m_out[b] = 0; m_ren[b] = 0; m_fen[b] = 0;
        m_hen[b] = 0; m_len[b] = 0; m_sts[b] = 0; m_edg[b] = 0;
        m_s1[b] = 0; m_s2[b] = 0; m_prev[b] = 0;
      end
    end else begin
      for (int b = 0; b < NB; b++) begin
        logic [W-1:0] lv, ev_e, ev_s, sclr, eclr;
        bit hit;
        lv   = m_s2[b] ^ m_pol[b];
        ev_e = (lv & ~m_prev[b] & m_ren[b]) | (~lv & m_prev[b] & m_fen[b]);
        ev_s = ev_e | (lv & m_hen[b]) | (~lv & m_len[b]);
        sclr = 0; eclr = 0;
        hit = wr && addr[1:0] == 0 && int'(addr[3:2]) == b;
        if (hit) begin
          case (addr[7:4])
            0:  m_dir[b] = wdata;
            1:  m_pol[b] = wdata;
            2:  m_out[b] = wdata;
            3:  m_out[b] = m_out[b] | wdata;
            4:  m_out[b] = m_out[b] & ~wdata;
            5:  m_ren[b] = wdata;
            6:  m_fen[b] = wdata;
            7:  m_hen[b] = wdata;
            8:  m_len[b] = wdata;
            9:  sclr = wdata;
            10: eclr = wdata;
            default: ;
          endcase
        end
        m_sts[b]  = (m_sts[b] & ~sclr) | ev_s;
        m_edg[b]  = (m_edg[b] & ~eclr) | ev_e;
        m_prev[b] = lv;
        m_s2[b]   = m_s1[b];
        m_s1[b]   = pin_i[b*W +: W];
      end
    end
  end

  function automatic logic [W-1:0] model_read(logic [7:0] a);
    int b;
    b = int'(a[3:2]);
    if (a[1:0] != 0 || b >= NB) return '0;
    case (a[7:4])
      0:  return m_dir[b];
      1:  return m_pol[b];
      2:  return (m_dir[b] & m_out[b]) | (~m_dir[b] & (m_s2[b] ^ m_pol[b]));
      5:  return m_ren[b];
      6:  return m_fen[b];
      7:  return m_hen[b];
      8:  return m_len[b];
      9:  return m_sts[b];
      10: return m_edg[b];
      default: return '0;
    endcase
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison of the pin and interrupt outputs (R2, R10)
  always @(negedge clk) if (rst_n && !done) begin
    logic any;
    any = 0;
    for (int b = 0; b < NB; b++) any |= |m_sts[b];
    total++;
    if (irq !== any) begin
      bad++; $display("FAIL R10 irq act=%b exp=%b", irq, any);
    end
    for (int b = 0; b < NB; b++) begin
      if (pin_o[b*W +: W] !== m_out[b] || pin_oe[b*W +: W] !== m_dir[b]) begin
        bad++;
        $display("FAIL R2 bank%0d out act=%h exp=%h oe act=%h exp=%h",
                 b, pin_o[b*W +: W], m_out[b], pin_oe[b*W +: W], m_dir[b]);
      end
    end
  end

  function automatic logic [7:0] ra(int fn, int b);
    return 8'((fn << 4) | (b << 2));
  endfunction

  task automatic wr_reg(logic [7:0] a, logic [W-1:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a);
    @(negedge clk); addr = a; #1;
    check(tag, rdata, model_read(a));
  endtask

  task automatic rd_lit(string tag, logic [7:0] a, logic [W-1:0] exp);
    @(negedge clk); addr = a; #1;
    check(tag, rdata, exp);
  endtask

  task automatic set_pins(int b, logic [W-1:0] v);
    @(negedge clk); pin_i[b*W +: W] = v;
  endtask

  initial begin
    #(WATCHDOG * 20);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12: reset state
    for (int b = 0; b < 4; b++)
      for (int f = 0; f < 16; f++) rd_lit("R12 reset read", ra(f, b), '0);
    check("R12 irq reset", W'(irq), '0);
    check("R12 oe reset", pin_oe[W-1:0], '0);

    // R2 / R3: direction, set and clear ports
    wr_reg(ra(0, 0), 32'h0000_00FF);
    wr_reg(ra(3, 0), 32'h0000_00A5);
    check("R3 set port", pin_o[W-1:0], 32'h0000_00A5);
    check("R2 oe", pin_oe[W-1:0], 32'h0000_00FF);
    wr_reg(ra(4, 0), 32'h0000_0005);
    check("R3 clear port", pin_o[W-1:0], 32'h0000_00A0);
    rd_lit("R3 set port reads 0", ra(3, 0), '0);
    wr_reg(ra(2, 1), 32'hDEAD_BEEF);
    check("R3 data load", pin_o[W +: W], 32'hDEAD_BEEF);

    // R4: input readback latency
    wr_reg(ra(0, 1), 32'h0);
    set_pins(1, 32'h1234_5678);
    @(negedge clk); addr = ra(2, 1); #1; check("R4 one clock old", rdata, 32'h0);
    @(negedge clk); #1; check("R4 two clocks new", rdata, 32'h1234_5678);
    rd_lit("R4 data mixed", ra(2, 0), 32'h0000_00A0);

    // R5: inversion
    wr_reg(ra(1, 1), 32'hFFFF_0000);
    rd_lit("R5 inverted readback", ra(2, 1), 32'hEDCB_5678);
    wr_reg(ra(1, 1), 32'h0);

    // R6: rising edge timing on bank 2 bit 0
    wr_reg(ra(5, 2), 32'h1);
    set_pins(2, 32'h1);
    @(negedge clk); @(negedge clk); addr = ra(9, 2); #1;
    check("R6 not yet pending", rdata, 32'h0);
    @(negedge clk); #1;
    check("R6 rising pending", rdata, 32'h1);
    check("R10 irq raised", W'(irq), 32'h1);
    rd_lit("R11 edge flag", ra(10, 2), 32'h1);
    wr_reg(ra(9, 2), 32'h0);
    rd_lit("R8 write 0 keeps", ra(9, 2), 32'h1);
    wr_reg(ra(9, 2), 32'h1);
    rd_lit("R8 w1c clears", ra(9, 2), 32'h0);
    wr_reg(ra(10, 2), 32'h1);
    rd_lit("R11 edge w1c", ra(10, 2), 32'h0);
    // both edges on bit 2
    wr_reg(ra(5, 2), 32'h4); wr_reg(ra(6, 2), 32'h4);
    set_pins(2, 32'h5); repeat (4) @(negedge clk);
    rd_lit("R6 both rise", ra(9, 2), 32'h4);
    wr_reg(ra(9, 2), 32'hFFFF_FFFF);
    set_pins(2, 32'h1); repeat (4) @(negedge clk);
    rd_lit("R6 both fall", ra(9, 2), 32'h4);
    wr_reg(ra(9, 2), 32'hFFFF_FFFF);
    wr_reg(ra(5, 2), 0); wr_reg(ra(6, 2), 0);

    // R7: level high on bank 0 bit 8
    wr_reg(ra(7, 0), 32'h100);
    set_pins(0, 32'h100); repeat (4) @(negedge clk);
    wr_reg(ra(9, 0), 32'h100);
    rd_lit("R7 level persists", ra(9, 0), 32'h100);
    rd_lit("R11 level no edge flag", ra(10, 0), 32'h0);
    set_pins(0, 32'h0); repeat (3) @(negedge clk);
    wr_reg(ra(9, 0), 32'h100);
    rd_lit("R7 cleared after level gone", ra(9, 0), 32'h0);
    wr_reg(ra(7, 0), 0);

    // R9: masked pins toggle without effect
    set_pins(0, 32'hFFFF_0000); repeat (4) @(negedge clk);
    set_pins(0, 32'h0); repeat (4) @(negedge clk);
    rd_lit("R9 masked no pending", ra(9, 0), 32'h0);
    check("R9 irq quiet", W'(irq), 32'h0);

    // R1: decode of unmapped slots
    wr_reg(8'hB0, 32'hFFFF_FFFF); wr_reg(8'h0C, 32'hFFFF_FFFF); wr_reg(8'h01, 32'hFFFF_FFFF);
    rd_lit("R1 unmapped fn", 8'hB0, 32'h0);
    rd_lit("R1 bank slot 3", 8'h0C, 32'h0);
    rd_lit("R1 misaligned", 8'h01, 32'h0);
    rd_lit("R1 dir untouched", ra(0, 0), 32'h0000_00FF);

    // mixed stimulus checked against the model
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = $urandom_range(0, 9);
      if (k < 3) set_pins($urandom_range(0, NB - 1), $urandom & $urandom);
      else if (k < 7) wr_reg(8'($urandom_range(0, 11) << 4 | $urandom_range(0, 3) << 2),
                             $urandom & $urandom);
      else rd_chk("R1 R4 R6 R7 R8 R11 mixed read",
                  8'($urandom_range(0, 11) << 4 | $urandom_range(0, 3) << 2));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule